// File: doc/BRIEF.md
# Safe Petri Net Firing Engine

This block runs a Petri net in which every place holds either zero tokens or one. The current marking is kept as one bit per place. The structure of the net is fixed when the block is elaborated. For each transition, three masks describe it:

- a consume mask: places whose token is taken when the transition fires;
- a test mask: places that must hold a token but keep it;
- a deposit mask: places that receive a token.

Each transition also has a label and a local/input attribute. A list of priority pairs names, for each pair, a higher transition and a lower one.

In every cycle the block works out the enabled set from the marking. It also raises a conflict indication, meaning that the net's outputs do not persist: two enabled transitions with different labels, at least one of them local, compete for a token that at least one of them would consume. It also shows a deadlock indication.

On a fire strobe the block fires one transition. It is either the one named on the select input, or one picked by a pseudo-random generator with a round-robin scan. The marking, the index of the fired transition and the fired strobe all appear one cycle after the fire strobe.

A controller or a test environment uses the block to step the net token by token. Between steps it reads the enabled set, the conflict flag and the deadlock flag.

Top module: `petri_engine`

## Requirements
- R1: Transition t is reported in `enabledSet` bit t exactly when every place in its consume mask and in its test mask holds a token in the current marking.
- R2: When transition t fires, the marking seen after the next clock edge has its consume-mask places cleared and its deposit-mask places set. Test-mask places are left as they were. `firedValid` pulses for that cycle and `firedIdx` equals t.
- R3: With `useRandom` low, a strobe whose `selIdx` names a fireable transition fires it. A strobe whose `selIdx` is not fireable, or is at least NT, leaves the marking unchanged and pulses `illegalReq` for one cycle instead of `firedValid`.
- R4: For each priority pair (hi, lo), lo cannot fire in any marking where hi is enabled, although lo still shows in `enabledSet`.
- R5: `conflict` is high exactly when two enabled transitions have different labels, at least one of them is local, and they share a place that at least one of them consumes.
- R6: `deadlock` is high exactly when `enabledSet` is all zero.
- R7: A firing that deposits a token on a place that is still marked after consumption sets `safetyErr`. `safetyErr` stays set until reset, and the place stays at one token.
- R8: With `useRandom` high, a strobe fires some fireable transition whenever one exists and never pulses `illegalReq`. With nothing fireable, it does nothing.
- R9: While `rst` is high at a clock edge, the marking loads the initial marking (places 0, 2 and 5 marked, value 8'h25 by default). `firedValid`, `illegalReq` and `safetyErr` are cleared.
- R10: Without a fire strobe the marking does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fireReq | input | 1 | Fire strobe |
| useRandom | input | 1 | 1: pseudo-random pick, 0: use selIdx |
| selIdx | input | 5 | Requested transition index |
| enabledSet | output | NT | Enabled transitions in the current marking |
| conflict | output | 1 | Output-persistency conflict in the current marking |
| deadlock | output | 1 | No transition enabled |
| marking | output | NP | Current marking, one bit per place |
| firedValid | output | 1 | A transition fired at the last edge |
| firedIdx | output | 5 | Index of the last fired transition |
| illegalReq | output | 1 | Last strobe named a transition that could not fire |
| safetyErr | output | 1 | Sticky token-overflow error |

## Verification
A wrong bit in the marking register shows at once in `marking`, and in the same cycle it usually changes `enabledSet`, `conflict` or `deadlock`. A wrong consume or deposit path shows up on the first firing of the affected transition. A wrong priority or enable decision shows as a missing or spurious `illegalReq`, or a missing `firedValid`, one cycle after the strobe. The bench replays every step on its own token model and compares all outputs every cycle, so any divergence is reported at the step where it first appears.

// File: rtl/pn_pkg.sv
package pn_pkg;
  localparam int IDX_W = 5;

  typedef struct packed {
    logic             fire;
    logic [IDX_W-1:0] idx;
    logic             illegal;
  } fireCmd_t;
endpackage

// File: rtl/pn_eval.sv
module pn_eval import pn_pkg::*; #(
  parameter int NP = 8,
  parameter int NT = 8,
  parameter int NUM_PRIO = 1,
  parameter logic [NT-1:0][NP-1:0] PRE_MASK = '0,
  parameter logic [NT-1:0][NP-1:0] READ_MASK = '0,
  parameter logic [NT-1:0][7:0] LABEL = '0,
  parameter logic [NT-1:0] LOCAL_MASK = '0,
  parameter logic [NUM_PRIO-1:0][IDX_W-1:0] PRIO_HI = '0,
  parameter logic [NUM_PRIO-1:0][IDX_W-1:0] PRIO_LO = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] marking,
  output logic [NT-1:0] enabled,
  output logic [NT-1:0] fireable,
  output logic          conflict,
  output logic          deadlock
);
  localparam int TW = (NT > 1) ? $clog2(NT) : 1;

  logic [NT-1:0] suppressed;

  function automatic logic pairEligible(input int i, input int j);
    logic [NP-1:0] hardShare;
    hardShare = (PRE_MASK[i] | READ_MASK[i]) & (PRE_MASK[j] | READ_MASK[j])
              & (PRE_MASK[i] | PRE_MASK[j]);
    return (|hardShare) && (LABEL[i] != LABEL[j]) && (LOCAL_MASK[i] | LOCAL_MASK[j]);
  endfunction

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      enabled[t] = ((PRE_MASK[t] | READ_MASK[t]) & ~marking) == '0;
    end
  end

  always_comb begin
    suppressed = '0;
    for (int k = 0; k < NUM_PRIO; k++) begin
      if (enabled[PRIO_HI[k][TW-1:0]]) suppressed[PRIO_LO[k][TW-1:0]] = 1'b1;
    end
  end

  assign fireable = enabled & ~suppressed;
  assign deadlock = ~|enabled;

  always_comb begin
    conflict = 1'b0;
    for (int i = 0; i < NT; i++) begin
      for (int j = i + 1; j < NT; j++) begin
        if (enabled[i] && enabled[j] && pairEligible(i, j)) conflict = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NUM_PRIO; k++) begin : gPrioChk
    AST_PRIO_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
      fireable[PRIO_HI[k][TW-1:0]] |-> !fireable[PRIO_LO[k][TW-1:0]]); // R4
  end
endmodule

// File: rtl/pn_ctrl.sv
module pn_ctrl import pn_pkg::*; #(
  parameter int NT = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fireReq,
  input  logic             useRandom,
  input  logic [IDX_W-1:0] selIdx,
  input  logic [NT-1:0]    fireable,
  output fireCmd_t         cmd
);
  localparam int TW = (NT > 1) ? $clog2(NT) : 1;

  logic [15:0]   lfsr;
  logic [TW-1:0] startIdx;
  logic [TW-1:0] cand;
  logic [TW-1:0] rndIdx;
  logic          rndHit;
  logic          selOk;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= LFSR_SEED;
    else     lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
  end

  assign startIdx = TW'(lfsr % 16'(NT));

  always_comb begin
    rndHit = 1'b0;
    rndIdx = '0;
    cand   = '0;
    for (int k = 0; k < NT; k++) begin
      cand = TW'((int'(startIdx) + k) % NT);
      if (!rndHit && fireable[cand]) begin
        rndHit = 1'b1;
        rndIdx = cand;
      end
    end
  end

  assign selOk = (int'(selIdx) < NT) && fireable[selIdx[TW-1:0]];

  always_comb begin
    cmd.fire    = fireReq && (useRandom ? rndHit : selOk);
    cmd.idx     = useRandom ? IDX_W'(rndIdx) : selIdx;
    cmd.illegal = fireReq && !useRandom && !selOk;
  end

  AST_RANDOM_PICKS: assert property (@(posedge clk) disable iff (rst)
    (fireReq && useRandom && (|fireable)) |-> cmd.fire); // R8
  AST_ILLEGAL_EXTERNAL_ONLY: assert property (@(posedge clk) disable iff (rst)
    cmd.illegal |-> (!useRandom && !cmd.fire)); // R3
endmodule

// File: rtl/pn_datapath.sv
module pn_datapath import pn_pkg::*; #(
  parameter int NP = 8,
  parameter int NT = 8,
  parameter logic [NT-1:0][NP-1:0] PRE_MASK = '0,
  parameter logic [NT-1:0][NP-1:0] READ_MASK = '0,
  parameter logic [NT-1:0][NP-1:0] POST_MASK = '0,
  parameter logic [NP-1:0] INIT_MARK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  fireCmd_t         cmd,
  output logic [NP-1:0]    marking,
  output logic             firedValid,
  output logic [IDX_W-1:0] firedIdx,
  output logic             illegalReq,
  output logic             safetyErr
);
  localparam int TW = (NT > 1) ? $clog2(NT) : 1;

  logic [NP-1:0] afterTake;
  logic [NP-1:0] deposit;
  logic          overflow;

  assign afterTake = marking & ~PRE_MASK[cmd.idx[TW-1:0]];
  assign deposit   = POST_MASK[cmd.idx[TW-1:0]];
  assign overflow  = |(afterTake & deposit);

  always_ff @(posedge clk) begin
    if (rst) begin
      marking    <= INIT_MARK;
      firedValid <= 1'b0;
      firedIdx   <= '0;
      illegalReq <= 1'b0;
      safetyErr  <= 1'b0;
    end else begin
      firedValid <= cmd.fire;
      illegalReq <= cmd.illegal;
      if (cmd.fire) begin
        marking  <= afterTake | deposit;
        firedIdx <= cmd.idx;
        if (overflow) safetyErr <= 1'b1;
      end
    end
  end

  AST_FIRED_WAS_ENABLED: assert property (@(posedge clk) disable iff (rst)
    firedValid |-> (($past(marking) & (PRE_MASK[firedIdx[TW-1:0]] | READ_MASK[firedIdx[TW-1:0]]))
                    == (PRE_MASK[firedIdx[TW-1:0]] | READ_MASK[firedIdx[TW-1:0]]))); // R1
  AST_TEST_PLACES_KEPT: assert property (@(posedge clk) disable iff (rst)
    firedValid |-> ((marking & READ_MASK[firedIdx[TW-1:0]]) == READ_MASK[firedIdx[TW-1:0]])); // R2
  AST_HOLD_WITHOUT_FIRE: assert property (@(posedge clk) disable iff (rst)
    !firedValid |-> (marking == $past(marking))); // R10
  AST_FIRE_ILLEGAL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(firedValid && illegalReq)); // R3
  AST_SAFETY_STICKY: assert property (@(posedge clk) disable iff (rst)
    safetyErr |=> safetyErr); // R7
endmodule

// File: rtl/petri_engine.sv
module petri_engine import pn_pkg::*; #(
  parameter int NP = 8,
  parameter int NT = 8,
  parameter int NUM_PRIO = 1,
  parameter logic [NT-1:0][NP-1:0] PRE_MASK =
    {8'h80, 8'h40, 8'h30, 8'h10, 8'h08, 8'h02, 8'h01, 8'h01},
  parameter logic [NT-1:0][NP-1:0] READ_MASK =
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h00, 8'h00},
  parameter logic [NT-1:0][NP-1:0] POST_MASK =
    {8'h01, 8'h04, 8'h80, 8'h80, 8'h40, 8'h10, 8'h08, 8'h02},
  parameter logic [NT-1:0][7:0] LABEL =
    {8'h17, 8'h16, 8'h15, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10},
  parameter logic [NT-1:0] LOCAL_MASK = 8'hFD,
  parameter logic [NP-1:0] INIT_MARK = 8'h25,
  parameter logic [NUM_PRIO-1:0][IDX_W-1:0] PRIO_HI = 5'd5,
  parameter logic [NUM_PRIO-1:0][IDX_W-1:0] PRIO_LO = 5'd4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fireReq,
  input  logic             useRandom,
  input  logic [IDX_W-1:0] selIdx,
  output logic [NT-1:0]    enabledSet,
  output logic             conflict,
  output logic             deadlock,
  output logic [NP-1:0]    marking,
  output logic             firedValid,
  output logic [IDX_W-1:0] firedIdx,
  output logic             illegalReq,
  output logic             safetyErr
);
  logic [NT-1:0] fireable;
  fireCmd_t      cmd;

  pn_eval #(
    .NP(NP), .NT(NT), .NUM_PRIO(NUM_PRIO), .PRE_MASK(PRE_MASK), .READ_MASK(READ_MASK),
    .LABEL(LABEL), .LOCAL_MASK(LOCAL_MASK), .PRIO_HI(PRIO_HI), .PRIO_LO(PRIO_LO)
  ) uEval (
    .clk(clk), .rst(rst), .marking(marking), .enabled(enabledSet),
    .fireable(fireable), .conflict(conflict), .deadlock(deadlock)
  );

  pn_ctrl #(.NT(NT), .LFSR_SEED(LFSR_SEED)) uCtrl (
    .clk(clk), .rst(rst), .fireReq(fireReq), .useRandom(useRandom),
    .selIdx(selIdx), .fireable(fireable), .cmd(cmd)
  );

  pn_datapath #(
    .NP(NP), .NT(NT), .PRE_MASK(PRE_MASK), .READ_MASK(READ_MASK),
    .POST_MASK(POST_MASK), .INIT_MARK(INIT_MARK)
  ) uData (
    .clk(clk), .rst(rst), .cmd(cmd), .marking(marking), .firedValid(firedValid),
    .firedIdx(firedIdx), .illegalReq(illegalReq), .safetyErr(safetyErr)
  );
endmodule

// File: tb/petri_engine_test.sv
`timescale 1ns/1ps
module petri_engine_test;
  localparam int NP = 8;
  localparam int NT = 8;

  logic clk = 1'b0, rst = 1'b1, fireReq = 1'b0, useRandom = 1'b0;
  logic [4:0] selIdx = '0;
  logic [NT-1:0] enabledSet;
  logic conflict, deadlock, firedValid, illegalReq, safetyErr;
  logic [NP-1:0] marking;
  logic [4:0] firedIdx;

  petri_engine uut (
    .clk(clk), .rst(rst), .fireReq(fireReq), .useRandom(useRandom), .selIdx(selIdx),
    .enabledSet(enabledSet), .conflict(conflict), .deadlock(deadlock), .marking(marking),
    .firedValid(firedValid), .firedIdx(firedIdx), .illegalReq(illegalReq), .safetyErr(safetyErr)
  );

  always #2.5 clk = ~clk;

  // Net description (index = transition number)
  logic [7:0] bPre [NT] = '{8'h01, 8'h01, 8'h02, 8'h08, 8'h10, 8'h30, 8'h40, 8'h80};
  logic [7:0] bRd  [NT] = '{8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  logic [7:0] bPost[NT] = '{8'h02, 8'h08, 8'h10, 8'h40, 8'h80, 8'h80, 8'h04, 8'h01};
  logic [7:0] bLab [NT] = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17};
  bit         bLoc [NT] = '{1, 0, 1, 1, 1, 1, 1, 1};

  int checks = 0, fails = 0;
  logic [7:0] mMark;
  bit mErr;

  function automatic logic [7:0] mEn(logic [7:0] m);
    logic [7:0] e;
    for (int t = 0; t < NT; t++) e[t] = ((bPre[t] | bRd[t]) & ~m) == 8'h00;
    return e;
  endfunction

  function automatic logic [7:0] mFireable(logic [7:0] m);
    logic [7:0] e;
    e = mEn(m);
    if (e[5]) e[4] = 1'b0;  // priority: t5 over t4
    return e;
  endfunction

  function automatic bit mConf(logic [7:0] m);
    logic [7:0] e, sh;
    e = mEn(m);
    for (int i = 0; i < NT; i++)
      for (int j = i + 1; j < NT; j++) begin
        sh = (bPre[i] | bRd[i]) & (bPre[j] | bRd[j]) & (bPre[i] | bPre[j]);
        if (e[i] && e[j] && sh != 0 && bLab[i] != bLab[j] && (bLoc[i] || bLoc[j])) return 1'b1;
      end
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; fireReq = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    mMark = 8'h25; mErr = 1'b0;
    chk(marking == 8'h25, "R9", "reset marking", marking, 8'h25);
    chk(!firedValid && !illegalReq && !safetyErr, "R9", "reset flags",
        {firedValid, illegalReq, safetyErr}, 0);
    rst = 1'b0;
  endtask

  task automatic step(bit f, bit r, int s);
    logic [7:0] fm, rest;
    bit expF, expIll;
    int idx;
    string tag;
    fm = mFireable(mMark);
    fireReq = f; useRandom = r; selIdx = s[4:0];
    @(posedge clk); #1;
    tag = r ? "R8" : "R3";
    if (!f) begin expF = 0; expIll = 0; end
    else if (r) begin expF = (fm != 0); expIll = 0; end
    else begin expF = (s < NT) && fm[s]; expIll = !expF; end
    chk(firedValid == expF, tag, "firedValid", firedValid, expF);
    chk(illegalReq == expIll, tag, "illegalReq", illegalReq, expIll);
    if (expF && firedValid) begin
      idx = r ? int'(firedIdx) : s;
      if (r) chk(idx < NT && fm[idx[2:0]], "R8", "random pick fireable", idx, fm);
      else   chk(int'(firedIdx) == s, "R2", "firedIdx", firedIdx, s);
      if (idx < NT) begin
        rest = mMark & ~bPre[idx];
        if ((rest & bPost[idx]) != 0) mErr = 1'b1;
        mMark = rest | bPost[idx];
      end
    end
    chk(marking == mMark, f ? "R2" : "R10", "marking", marking, mMark);
    chk(safetyErr == mErr, "R7", "safetyErr", safetyErr, mErr);
    fireReq = 1'b0;
    @(negedge clk);
    chk(enabledSet == mEn(mMark), "R1", "enabledSet", enabledSet, mEn(mMark));
    chk(conflict == mConf(mMark), "R5", "conflict", conflict, mConf(mMark));
    chk(deadlock == (mEn(mMark) == 0), "R6", "deadlock", deadlock, mEn(mMark) == 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    chk(enabledSet == 8'h03, "R1", "initial enabled", enabledSet, 8'h03);
    chk(conflict == 1'b1, "R5", "t0/t1 conflict", conflict, 1);
    step(0, 0, 0);
    step(1, 0, 2);                 // not enabled: illegal (R3)
    step(1, 0, 9);                 // out of range: illegal (R3)
    step(1, 0, 0);
    chk(marking == 8'h26, "R2", "after t0", marking, 8'h26);
    step(1, 0, 2);
    chk(marking == 8'h34, "R2", "test place p2 kept", marking, 8'h34);
    chk(enabledSet == 8'h30, "R4", "lo still shown enabled", enabledSet, 8'h30);
    step(1, 0, 4);                 // suppressed by t5 (R4)
    chk(marking == 8'h34, "R4", "suppressed lo did not fire", marking, 8'h34);
    step(1, 0, 5);
    step(1, 0, 7);
    chk(marking == 8'h05, "R2", "back to p0,p2", marking, 8'h05);
    step(1, 0, 0);
    step(1, 0, 2);
    step(1, 0, 4);                 // hi not enabled now: fires
    chk(marking == 8'h84, "R4", "lo fires without hi", marking, 8'h84);
    step(1, 0, 7);
    step(1, 0, 1);
    step(1, 0, 3);
    step(1, 0, 6);                 // deposits onto marked p2
    chk(safetyErr == 1'b1, "R7", "overflow flagged", safetyErr, 1);
    chk(marking == 8'h04, "R7", "place stays single token", marking, 8'h04);
    chk(deadlock == 1'b1, "R6", "dead marking", deadlock, 1);
    step(0, 0, 0);
    step(0, 0, 0);
    step(1, 1, 0);                 // random with nothing fireable (R8)
    step(1, 0, 6);
    for (int k = 0; k < 5; k++) begin
      doReset();
      for (int w = 0; w < k; w++) step(0, 0, 0);
      for (int n = 0; n < 25; n++) step(1, 1, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule